// File: doc/BRIEF.md
# Accelerometer SPI Polling Controller

This block is a hardware sequencer that owns a four-wire SPI link to a three-axis accelerometer and brings it up without any processor help. Out of reset it issues a soft reset to the sensor, waits a recovery interval counted in system clocks, switches the sensor into measurement mode, and then reads the X, Y and Z acceleration bytes over and over for as long as it runs.

Each axis value is a signed 8-bit two's-complement number. The first two axes of a round are kept in shadow registers. All three published outputs change in the same cycle, together with a one-cycle valid strobe, once the Z byte has arrived. A consumer therefore never sees axes from two different rounds. The SCLK rate is set by a compile-time divide-by-2N parameter. The recovery wait is derived from the system clock frequency parameter.

Top module: `accel_poller`

## Requirements
- R1: SPI mode 0. SCLK is low whenever chip select (`spi_cs_n`, active low) is high. MOSI changes only while SCLK is low, and it holds its value through every SCLK high phase. MISO is sampled on the rising SCLK edge. Bytes are sent and received most-significant bit first.
- R2: SCLK high and low phases each last `DIV_N` system clocks, so one SCLK period is 2*`DIV_N` clocks.
- R3: A register write is a single 24-bit frame within one chip-select assertion. It consists of command byte 0x0A, then the register address byte, then the data byte.
- R4: A register read is a single 24-bit frame within one chip-select assertion. It consists of command byte 0x0B, then the address byte, then 8 bits clocked in from MISO while MOSI is held at 0.
- R5: The first frame after reset writes 0x52 to register 0x1F, which is the sensor soft reset.
- R6: After the soft-reset frame ends, chip select stays high for at least ceil(`CLK_HZ`/1000) clocks. The next frame then writes 0x02 to register 0x2D, which selects measurement mode.
- R7: After that, reads target registers 0x08 (X), 0x09 (Y) and 0x0A (Z), in that order, repeating indefinitely.
- R8: Under reset the outputs are zero. `accel_x`, `accel_y` and `accel_z` change only together, in the cycle `sample_valid` is high. `sample_valid` is high for exactly one cycle after each Z read. The outputs hold their old values while the X and Y reads of the next round complete.
- R9: Between frames, chip select is high for at least one full SCLK period (2*`DIV_N` clocks).
- R10: A received byte is published as a signed value. For example, 0x80 reads as -128, 0xF3 as -13, 0xFF as -1 and 0x7F as +127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |
| accel_x | output | 8 | Signed X-axis sample |
| accel_y | output | 8 | Signed Y-axis sample |
| accel_z | output | 8 | Signed Z-axis sample |
| sample_valid | output | 1 | One-cycle strobe when a new X/Y/Z set is published |

## Verification
The bench builds the block with `CLK_HZ` = 2,000,000 and `DIV_N` = 2. With these values the recovery wait shrinks to 2000 clocks and each frame to roughly a hundred clocks. The whole bring-up and several complete polling rounds therefore fit in one short run. The small divider puts the SCLK half-period and the inter-frame chip-select gap at a few clocks. This makes an off-by-one in either the phase counter or the gap counter show up directly as a wrong measured period or gap. The sensor model returns a fresh set of values after each strobe, including 0x80, 0x7F, 0xFF and zero. This exercises both sign handling and the no-mixing rule across round boundaries.

// File: rtl/accel_poll_pkg.sv
package accel_poll_pkg;

  localparam int FRAME_W = 24;

  localparam logic [7:0] CMD_WRITE = 8'h0A;
  localparam logic [7:0] CMD_READ  = 8'h0B;
  localparam logic [7:0] ADDR_SRST = 8'h1F;
  localparam logic [7:0] SRST_CODE = 8'h52;
  localparam logic [7:0] ADDR_PWR  = 8'h2D;
  localparam logic [7:0] PWR_MEAS  = 8'h02;
  localparam logic [7:0] ADDR_XDAT = 8'h08;
  localparam logic [7:0] ADDR_YDAT = 8'h09;
  localparam logic [7:0] ADDR_ZDAT = 8'h0A;

  typedef enum logic [1:0] {
    E_IDLE,
    E_SHIFT,
    E_GAP
  } eng_st_t;

  typedef enum logic [2:0] {
    S_SRST,
    S_WAIT,
    S_MEAS,
    S_RDX,
    S_RDY,
    S_RDZ
  } seq_st_t;

  function automatic logic [FRAME_W-1:0] wr_frame(input logic [7:0] addr, input logic [7:0] data);
    return {CMD_WRITE, addr, data};
  endfunction

  function automatic logic [FRAME_W-1:0] rd_frame(input logic [7:0] addr);
    return {CMD_READ, addr, 8'h00};
  endfunction

  // clocks in 1 ms, rounded up, never below one
  function automatic int wait_clks(input longint clk_hz);
    longint c;
    c = (clk_hz + 64'd999) / 64'd1000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic seq_st_t seq_next(input seq_st_t s);
    case (s)
      S_SRST:  return S_WAIT;
      S_MEAS:  return S_RDX;
      S_RDX:   return S_RDY;
      S_RDY:   return S_RDZ;
      S_RDZ:   return S_RDX;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/accel_spi_engine.sv
module accel_spi_engine
  import accel_poll_pkg::*;
#(
  parameter int DIV_N      = 4,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  idle,
  output logic                  done,
  output logic [7:0]            rx_byte,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);

  localparam int HCW      = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam int GAP_CLKS = 2 * DIV_N;
  localparam int GCW      = $clog2(GAP_CLKS + 1);
  localparam int BCW      = $clog2(FRAME_BITS);
  localparam logic [HCW-1:0] HC_LAST  = HCW'(DIV_N - 1);
  localparam logic [GCW-1:0] GC_LAST  = GCW'(GAP_CLKS - 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(FRAME_BITS - 1);

  eng_st_t               st;
  logic [HCW-1:0]        hcnt;
  logic [GCW-1:0]        gcnt;
  logic [BCW-1:0]        bitn;
  logic [FRAME_BITS-1:0] sh;
  logic                  tick;

  assign tick = (hcnt == HC_LAST);
  assign idle = (st == E_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      hcnt    <= '0;
      gcnt    <= '0;
      bitn    <= '0;
      sh      <= '0;
      rx_byte <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            sh   <= frame;
            mosi <= frame[FRAME_BITS-1];
            cs_n <= 1'b0;
            hcnt <= '0;
            bitn <= '0;
            st   <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (tick) begin
            hcnt <= '0;
            sclk <= ~sclk;
            if (!sclk) begin
              rx_byte <= {rx_byte[6:0], miso};
            end else if (bitn == BIT_LAST) begin
              cs_n <= 1'b1;
              mosi <= 1'b0;
              gcnt <= '0;
              st   <= E_GAP;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[FRAME_BITS-2:0], 1'b0};
              mosi <= sh[FRAME_BITS-2];
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        E_GAP: begin
          if (gcnt == GC_LAST) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/accel_seq.sv
module accel_seq
  import accel_poll_pkg::*;
#(
  parameter int WAIT_CLKS = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eng_idle,
  input  logic               eng_done,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_frame,
  output logic               cap_x,
  output logic               cap_y,
  output logic               cap_z
);

  localparam int WCW = $clog2(WAIT_CLKS + 1);
  localparam logic [WCW-1:0] W_LAST = WCW'(WAIT_CLKS - 1);

  seq_st_t        st;
  logic           issued;
  logic [WCW-1:0] wcnt;
  logic           wants_frame;

  assign wants_frame = (st != S_WAIT);
  assign eng_start   = wants_frame && !issued && eng_idle;
  assign cap_x       = eng_done && (st == S_RDX);
  assign cap_y       = eng_done && (st == S_RDY);
  assign cap_z       = eng_done && (st == S_RDZ);

  always_comb begin
    case (st)
      S_SRST:  eng_frame = wr_frame(ADDR_SRST, SRST_CODE);
      S_MEAS:  eng_frame = wr_frame(ADDR_PWR, PWR_MEAS);
      S_RDX:   eng_frame = rd_frame(ADDR_XDAT);
      S_RDY:   eng_frame = rd_frame(ADDR_YDAT);
      S_RDZ:   eng_frame = rd_frame(ADDR_ZDAT);
      default: eng_frame = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_SRST;
      issued <= 1'b0;
      wcnt   <= '0;
    end else begin
      if (eng_done) begin
        issued <= 1'b0;
        st     <= seq_next(st);
      end else if (eng_start) begin
        issued <= 1'b1;
      end
      if (st == S_WAIT) begin
        if (wcnt == W_LAST) begin
          wcnt <= '0;
          st   <= S_MEAS;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/accel_sample_hold.sv
module accel_sample_hold (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_x,
  input  logic              cap_y,
  input  logic              cap_z,
  input  logic [7:0]        din,
  output logic signed [7:0] out_x,
  output logic signed [7:0] out_y,
  output logic signed [7:0] out_z,
  output logic              valid
);

  logic [7:0] shadow_x;
  logic [7:0] shadow_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_x <= '0;
      shadow_y <= '0;
      out_x    <= '0;
      out_y    <= '0;
      out_z    <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (cap_x) shadow_x <= din;
      if (cap_y) shadow_y <= din;
      if (cap_z) begin
        out_x <= signed'(shadow_x);
        out_y <= signed'(shadow_y);
        out_z <= signed'(din);
        valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/accel_poller.sv
module accel_poller
  import accel_poll_pkg::*;
#(
  parameter longint CLK_HZ = 100_000_000,
  parameter int     DIV_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic signed [7:0] accel_x,
  output logic signed [7:0] accel_y,
  output logic signed [7:0] accel_z,
  output logic              sample_valid
);

  localparam int WAIT_CLKS = wait_clks(CLK_HZ);

  logic               eng_start;
  logic               eng_idle;
  logic               eng_done;
  logic [FRAME_W-1:0] eng_frame;
  logic [7:0]         eng_rx;
  logic               cap_x;
  logic               cap_y;
  logic               cap_z;

  accel_seq #(.WAIT_CLKS(WAIT_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_idle  (eng_idle),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .eng_frame (eng_frame),
    .cap_x     (cap_x),
    .cap_y     (cap_y),
    .cap_z     (cap_z)
  );

  accel_spi_engine #(.DIV_N(DIV_N), .FRAME_BITS(FRAME_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .frame   (eng_frame),
    .idle    (eng_idle),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  accel_sample_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_x (cap_x),
    .cap_y (cap_y),
    .cap_z (cap_z),
    .din   (eng_rx),
    .out_x (accel_x),
    .out_y (accel_y),
    .out_z (accel_z),
    .valid (sample_valid)
  );

endmodule

// File: rtl/accel_poller_chk.sv
module accel_poller_chk #(
  parameter int DIV_N = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic sample_valid,
  input logic eng_start,
  input logic eng_idle
);

  logic [15:0] hi_cnt;
  logic [15:0] ph_cnt;
  logic        prev_sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= 16'hFFFF;
      ph_cnt    <= 16'd0;
      prev_sclk <= 1'b0;
    end else begin
      prev_sclk <= spi_sclk;
      if (!spi_cs_n) hi_cnt <= 16'd0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
      if (spi_sclk != prev_sclk) ph_cnt <= 16'd1;
      else if (ph_cnt != 16'hFFFF) ph_cnt <= ph_cnt + 16'd1;
    end
  end

  // R1
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R1
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R2
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> (ph_cnt == 16'(DIV_N)));

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(2 * DIV_N)));

  // R9
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_idle);

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

endmodule

bind accel_poller accel_poller_chk #(.DIV_N(DIV_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spi_sclk     (spi_sclk),
  .spi_cs_n     (spi_cs_n),
  .spi_mosi     (spi_mosi),
  .sample_valid (sample_valid),
  .eng_start    (eng_start),
  .eng_idle     (eng_idle)
);

// File: tb/sim_accel_poller.sv
`timescale 1ns/1ps
module sim_accel_poller;

  localparam longint CLK_HZ = 2_000_000;
  localparam int     DIV_N  = 2;
  localparam int     WAIT_EXP = int'((CLK_HZ + 999) / 1000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic signed [7:0] accel_x, accel_y, accel_z;
  logic sample_valid;

  always #2.5 clk = ~clk;

  accel_poller #(.CLK_HZ(CLK_HZ), .DIV_N(DIV_N)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .accel_x(accel_x),
    .accel_y(accel_y), .accel_z(accel_z), .sample_valid(sample_valid)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sensor model
  logic [7:0]  resp_x = 8'h12, resp_y = 8'hF3, resp_z = 8'h80;
  logic [23:0] frames [0:63];
  int          fbits  [0:63];
  realtime     t_fall [0:63];
  realtime     t_rise [0:63];
  int          nf = 0;
  int          bitcnt = 0;
  logic [23:0] sh = '0;
  bit          in_frame = 0;
  realtime     first_rise = 0;
  realtime     sclk_per = 0;
  logic [7:0]  cur_resp;

  function automatic logic [7:0] pick(input logic [7:0] a);
    case (a)
      8'h08: return resp_x;
      8'h09: return resp_y;
      8'h0A: return resp_z;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge spi_cs_n) begin
    in_frame = 1;
    bitcnt = 0;
    sh = '0;
    if (nf < 64) t_fall[nf] = $realtime;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[22:0], spi_mosi};
    bitcnt++;
    if (bitcnt == 1) first_rise = $realtime;
    if (bitcnt == 2) sclk_per = $realtime - first_rise;
    if (bitcnt == 16) cur_resp = pick(sh[7:0]);
  end

  always @(negedge spi_sclk) if (!spi_cs_n && bitcnt >= 16 && bitcnt < 24)
    spi_miso = cur_resp[23 - bitcnt];

  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0;
    if (nf < 64) begin
      frames[nf] = sh;
      fbits[nf]  = bitcnt;
      t_rise[nf] = $realtime;
    end
    nf++;
  end

  // R1 pin-level monitor
  int  r1_viol = 0;
  logic pm_sclk = 0, pm_mosi = 0;
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n && spi_sclk) r1_viol++;
    if (spi_sclk && pm_sclk && (spi_mosi != pm_mosi)) r1_viol++;
    pm_sclk = spi_sclk;
    pm_mosi = spi_mosi;
  end

  task automatic wait_valid(output int width);
    width = 0;
    while (!sample_valid) @(negedge clk);
    while (sample_valid) begin width++; @(negedge clk); end
  endtask

  task automatic check_xyz(input string tag, input int ex, input int ey, input int ez);
    chk(accel_x == ex, {tag, " x"}, accel_x, ex);
    chk(accel_y == ey, {tag, " y"}, accel_y, ey);
    chk(accel_z == ez, {tag, " z"}, accel_z, ez);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check_xyz("R8 reset", 0, 0, 0);
    chk(sample_valid == 0, "R8 reset valid", sample_valid, 0);
    chk(spi_cs_n == 1, "R1 reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 0, "R1 reset sclk", spi_sclk, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_init;
    while (nf < 2) @(negedge clk);
    chk(frames[0] == 24'h0A1F52, "R5 soft reset frame", frames[0], 24'h0A1F52);
    chk(fbits[0] == 24, "R3 write frame bits", fbits[0], 24);
    chk(frames[1] == 24'h0A2D02, "R6 measure frame", frames[1], 24'h0A2D02);
    chk(int'((t_fall[1] - t_rise[0]) / 5.0) >= WAIT_EXP, "R6 wait min",
        int'((t_fall[1] - t_rise[0]) / 5.0), WAIT_EXP);
    chk(int'((t_fall[1] - t_rise[0]) / 5.0) <= WAIT_EXP + 4 * DIV_N + 20, "R6 wait max",
        int'((t_fall[1] - t_rise[0]) / 5.0), WAIT_EXP + 4 * DIV_N + 20);
  endtask

  task automatic t_first_sample;
    int w;
    wait_valid(w);
    chk(w == 1, "R8 valid width", w, 1);
    check_xyz("R10 signed", 18, -13, -128);
    chk(frames[2] == 24'h0B0800, "R4 read X frame", frames[2], 24'h0B0800);
    chk(frames[3] == 24'h0B0900, "R7 read Y frame", frames[3], 24'h0B0900);
    chk(frames[4] == 24'h0B0A00, "R7 read Z frame", frames[4], 24'h0B0A00);
    chk(fbits[4] == 24, "R4 read frame bits", fbits[4], 24);
  endtask

  task automatic t_no_mix;
    int n0, w;
    resp_x = 8'h7F; resp_y = 8'h81; resp_z = 8'h01;
    n0 = nf;
    while (nf < n0 + 2) @(negedge clk);
    check_xyz("R8 hold mid-round", 18, -13, -128);
    wait_valid(w);
    chk(w == 1, "R8 valid width 2", w, 1);
    check_xyz("R10 extremes", 127, -127, 1);
  endtask

  task automatic t_patterns;
    int w;
    resp_x = 8'h00; resp_y = 8'h00; resp_z = 8'h00;
    wait_valid(w);
    check_xyz("R10 zero", 0, 0, 0);
    resp_x = 8'hFF; resp_y = 8'h00; resp_z = 8'h7F;
    wait_valid(w);
    check_xyz("R10 minus one", -1, 0, 127);
  endtask

  task automatic t_order_timing;
    int bad_ord = 0;
    int min_gap = 1000000;
    int lim = (nf < 64) ? nf : 64;
    for (int i = 2; i < lim; i++) begin
      logic [7:0] a;
      int g;
      a = 8'h08 + 8'((i - 2) % 3);
      if (frames[i] != {8'h0B, a, 8'h00}) bad_ord++;
      g = int'((t_fall[i] - t_rise[i-1]) / 5.0);
      if (g < min_gap) min_gap = g;
    end
    chk(bad_ord == 0, "R7 poll order", bad_ord, 0);
    chk(min_gap >= 2 * DIV_N, "R9 cs gap", min_gap, 2 * DIV_N);
    chk(int'(sclk_per / 5.0) == 2 * DIV_N, "R2 sclk period", int'(sclk_per / 5.0), 2 * DIV_N);
    chk(r1_viol == 0, "R1 mode 0 pins", r1_viol, 0);
  endtask

  initial begin
    t_reset;
    t_init;
    t_first_sample;
    t_no_mix;
    t_patterns;
    t_order_timing;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule